// File: doc/BRIEF.md
# Static Memory Bank Strobe Sequencer

This block turns a host read or write request into the strobe sequence for one asynchronous memory bank, a ROM or an SRAM. The memory sees an address bus, an active-low chip select, an active-low output enable for reads and an active-low write enable for writes. The length of each strobe phase is set by a small code field in a 15-bit timing word. Each code decodes to a clock count, and the mapping is not linear.

Software loads the timing word through a one-cycle write strobe. The word is copied into the sequencer when a request is accepted, so a new word only affects later requests. A read can run as a page burst of 4, 8 or 16 beats. In a burst, the first beat uses the normal access time and each later beat uses the shorter page access time. During a burst only the low beat-index address bits change. Every beat ends with a one-clock acknowledge pulse, and for reads this pulse comes with the captured data.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset, `req_ready` is 1, all three strobes are high, `mem_addr` is 0, `beat_ack` is 0, and the timing word is 0x700. With that word, a read spends 14 clocks in the access phase and 0 clocks in every other phase.
- R2: An accepted request runs its phases in this fixed order: address setup (chip select high, address driven), chip select setup (chip select low, enable high), access (enable low), chip select hold (enable high, chip select low), address hold (chip select high, address still driven), then idle. A phase of zero clocks is skipped and no cycle is inserted in its place.
- R3: Four 2-bit codes set four phase lengths: bits 14:13 set address setup, bits 12:11 set chip select setup, bits 7:6 set chip select hold, and bits 5:4 set address hold. Codes 0, 1, 2 and 3 give 0, 1, 2 and 4 clocks.
- R4: Bits 10:8 set the first-beat access length. Codes 0 to 7 give 1, 2, 3, 4, 6, 8, 10 and 14 clocks.
- R5: Bits 1:0 set the number of beats in a read: codes 0, 1, 2 and 3 give 1, 4, 8 and 16 beats. Every beat after the first lasts the page access time from bits 3:2, where codes 0, 1, 2 and 3 give 2, 3, 4 and 6 clocks. Output enable stays low across the whole burst.
- R6: A write always has exactly one beat, whatever bits 1:0 hold. Write enable goes low for the access phase instead of output enable, and `mem_wdata` carries the request's write data.
- R7: For a burst of N beats, beat k drives the request address with its low log2(N) bits replaced by (request address + k) mod N. All higher bits stay constant, and the index wraps around within the page.
- R8: Read data is sampled from `mem_rdata` on the last clock of each beat. In the next cycle `beat_ack` is high for exactly one cycle and `rd_data` holds the sample. Writes also raise `beat_ack` once.
- R9: `req_ready` is high only when the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its first phase starts in the next cycle. A request held during a transaction is accepted only after that transaction's address hold phase has ended.
- R10: A cycle with `cfg_we` high loads `cfg_word` into the timing register. A request uses the word in force when it is accepted; a write made during a transaction changes only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_word | input | 15 | New timing word |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Request start address |
| req_wdata | input | DW (16) | Write data |
| req_ready | output | 1 | Idle, able to take a request |
| beat_ack | output | 1 | One-cycle pulse per completed beat |
| rd_data | output | DW (16) | Last captured read data |
| mem_addr | output | AW (16) | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data |

## Verification
The first phase of a request appears one cycle after its accept edge. Each phase then lasts exactly its decoded clock count. `beat_ack` and `rd_data` show up one cycle after the last clock of a beat, and `req_ready` returns in the cycle after the last hold clock. At each accept edge the driver builds the complete expected cycle-by-cycle trace from the timing word it wrote: strobes, address, ready, acknowledge and data. The monitor compares one trace entry per clock at the falling edge, so every phase boundary is checked in the exact cycle it is due. When no trace is pending, the monitor checks that the block is idle.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  localparam int TW_W      = 15;
  localparam int ASU_LSB   = 13;
  localparam int CSU_LSB   = 11;
  localparam int ACC_LSB   = 8;
  localparam int CSH_LSB   = 6;
  localparam int AH_LSB    = 4;
  localparam int PACC_LSB  = 2;
  localparam int BEATS_LSB = 0;
  localparam int LEN_W     = 4;
  localparam int BEAT_W    = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_PAGE, PH_CSH, PH_AH
  } phase_e;

  typedef struct packed {
    logic [LEN_W-1:0]  asu;
    logic [LEN_W-1:0]  csu;
    logic [LEN_W-1:0]  acc;
    logic [LEN_W-1:0]  pacc;
    logic [LEN_W-1:0]  csh;
    logic [LEN_W-1:0]  ah;
    logic [BEAT_W-1:0] beats;
  } tim_s;

  function automatic logic [LEN_W-1:0] dly_clocks(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] acc_clocks(input logic [2:0] c);
    case (c)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] page_clocks(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd2;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd6;
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] beat_count(input logic [1:0] c);
    case (c)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Next non-empty phase in the fixed strobe order
  function automatic phase_e next_phase(input phase_e p, input tim_s t, input logic more);
    phase_e n;
    case (p)
      PH_IDLE: n = (t.asu != 0) ? PH_ASU : ((t.csu != 0) ? PH_CSU : PH_ACC);
      PH_ASU:  n = (t.csu != 0) ? PH_CSU : PH_ACC;
      PH_CSU:  n = PH_ACC;
      PH_ACC, PH_PAGE:
        if (more)            n = PH_PAGE;
        else if (t.csh != 0) n = PH_CSH;
        else if (t.ah != 0)  n = PH_AH;
        else                 n = PH_IDLE;
      PH_CSH:  n = (t.ah != 0) ? PH_AH : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [LEN_W-1:0] phase_len(input phase_e p, input tim_s t);
    case (p)
      PH_ASU:  return t.asu;
      PH_CSU:  return t.csu;
      PH_ACC:  return t.acc;
      PH_PAGE: return t.pacc;
      PH_CSH:  return t.csh;
      PH_AH:   return t.ah;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sseq_timing_dec.sv
module sseq_timing_dec
  import sseq_pkg::*;
(
  input  logic [TW_W-1:0] word,
  output tim_s            tim
);

  always_comb begin
    tim.asu   = dly_clocks(word[ASU_LSB +: 2]);
    tim.csu   = dly_clocks(word[CSU_LSB +: 2]);
    tim.acc   = acc_clocks(word[ACC_LSB +: 3]);
    tim.pacc  = page_clocks(word[PACC_LSB +: 2]);
    tim.csh   = dly_clocks(word[CSH_LSB +: 2]);
    tim.ah    = dly_clocks(word[AH_LSB +: 2]);
    tim.beats = beat_count(word[BEATS_LSB +: 2]);
  end

endmodule

// File: rtl/sseq_phase_timer.sv
module sseq_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_len - 1'b1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R4: a loaded phase counts down one clock at a time
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tim_s             tim,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             phase_last,
  output logic             timer_load,
  output logic [LEN_W-1:0] timer_len,
  output logic             req_ready,
  output logic             beat_ack,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_wdata
);

  localparam int PAD_W = AW - BEAT_W;

  phase_e            state_q, state_d;
  tim_s              tim_q, tsel;
  logic              write_q;
  logic [AW-1:0]     base_q, addr_q, addr_d, page_addr, mask;
  logic [DW-1:0]     wdata_q, rd_q;
  logic [BEAT_W-1:0] beat_q, beat_d, beat_nx;
  logic              ack_q;
  logic              accept, advance, in_access, beat_end, more;

  // ---------------- next-state logic ----------------
  always_comb begin
    accept    = (state_q == PH_IDLE) && req_valid;
    tsel      = accept ? tim : tim_q;
    in_access = (state_q == PH_ACC) || (state_q == PH_PAGE);
    beat_end  = in_access && phase_last;
    advance   = accept || ((state_q != PH_IDLE) && phase_last);
    beat_nx   = beat_q + 1'b1;
    more      = !write_q && (beat_nx < tim_q.beats);

    state_d = state_q;
    if (advance)
      state_d = next_phase(state_q, tsel, more);
    timer_load = advance && (state_d != PH_IDLE);
    timer_len  = phase_len(state_d, tsel);

    mask      = {{PAD_W{1'b0}}, tim_q.beats - 1'b1};
    page_addr = (base_q & ~mask) | ((base_q + {{PAD_W{1'b0}}, beat_nx}) & mask);

    beat_d = beat_q;
    if (accept)        beat_d = '0;
    else if (beat_end) beat_d = beat_nx;

    addr_d = addr_q;
    if (accept)                           addr_d = req_addr;
    else if (beat_end && more)            addr_d = page_addr;
    else if (advance && state_d == PH_IDLE) addr_d = '0;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      tim_q   <= '0;
      write_q <= 1'b0;
      base_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      addr_q  <= addr_d;
      ack_q   <= beat_end;
      if (accept) begin
        tim_q   <= tim;
        write_q <= req_write;
        base_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (beat_end && !write_q)
        rd_q <= mem_rdata;
    end
  end

  // ---------------- outputs ----------------
  assign req_ready = (state_q == PH_IDLE);
  assign beat_ack  = ack_q;
  assign rd_data   = rd_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_cs_n  = !((state_q == PH_CSU) || in_access || (state_q == PH_CSH));
  assign mem_oe_n  = !(in_access && !write_q);
  assign mem_we_n  = !((state_q == PH_ACC) && write_q);

  // ---------------- assertions ----------------
  // R9: ready only drops because a request was taken
  a_r9_drop_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  // R8: acknowledge lasts exactly one cycle
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ack |=> !beat_ack);

  // R8: acknowledge follows an access clock
  a_r8_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ack |-> ($past(state_q) == PH_ACC || $past(state_q) == PH_PAGE));

  // R7: page beats keep the upper address bits
  a_r7_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_PAGE) |-> ((addr_q & ~mask) == ($past(addr_q) & ~mask)));

  // R6: writes never enter page beats
  a_r6_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_PAGE) |-> !write_q);

  // R10: snapshot stays fixed during a transaction
  a_r10_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && $past(state_q) != PH_IDLE) |-> $stable(tim_q));

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sseq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter logic [TW_W-1:0] CFG_RESET = 15'h0700
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [TW_W-1:0] cfg_word,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            beat_ack,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_cs_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);

  logic [1:0]       rst_sync_q;
  logic             srst_n;
  logic [TW_W-1:0]  cfg_q;
  tim_s             tim;
  logic             timer_load, phase_last;
  logic [LEN_W-1:0] timer_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_word;
  end

  sseq_timing_dec u_dec (
    .word (cfg_q),
    .tim  (tim)
  );

  sseq_phase_timer #(.CNT_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (timer_load),
    .load_len (timer_len),
    .last     (phase_last)
  );

  sseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .tim        (tim),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_rdata  (mem_rdata),
    .phase_last (phase_last),
    .timer_load (timer_load),
    .timer_len  (timer_len),
    .req_ready  (req_ready),
    .beat_ack   (beat_ack),
    .rd_data    (rd_data),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_wdata  (mem_wdata)
  );

  // R2: an enable strobe is only low inside chip select
  a_r2_enable_in_cs: assert property (@(posedge clk) disable iff (!srst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

endmodule

// File: tb/sim_sram_strobe_seq.sv
module sim_sram_strobe_seq;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [14:0] cfg_word;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready, beat_ack;
  logic [15:0] rd_data, mem_addr, mem_wdata, mem_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n;

  typedef struct {
    logic cs, oe, we, rdy, ack, chk_rd, chk_wd;
    logic [15:0] addr, rd, wd;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    total, bad;
  bit    done;
  logic [14:0] model_cfg;
  logic        pend_ack, cur_wr;
  logic [15:0] pend_rd, cur_wd;

  sram_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .beat_ack(beat_ack),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] rdf(input logic [15:0] a);
    return {a[3:0], a[15:4]} ^ 16'h3C5A;
  endfunction

  assign mem_rdata = mem_oe_n ? 16'h0000 : rdf(mem_addr);

  function automatic int d2(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction
  function automatic int dacc(input logic [2:0] c);
    int t[8] = '{1, 2, 3, 4, 6, 8, 10, 14};
    return t[c];
  endfunction
  function automatic int dpage(input logic [1:0] c);
    int t[4] = '{2, 3, 4, 6};
    return t[c];
  endfunction
  function automatic int dbeats(input logic [1:0] c);
    int t[4] = '{1, 4, 8, 16};
    return t[c];
  endfunction
  function automatic logic [14:0] mk(input logic [1:0] asu, csu, input logic [2:0] acc,
                                     input logic [1:0] csh, ah, pg, pmc);
    return {asu, csu, acc, csh, ah, pg, pmc};
  endfunction

  task automatic add_cyc(input logic cs, oe, we, input logic [15:0] a,
                         input logic rdy, input string t);
    exp_t e;
    e.cs = cs; e.oe = oe; e.we = we; e.addr = a; e.rdy = rdy;
    e.ack = pend_ack; e.chk_rd = pend_ack && !cur_wr; e.rd = pend_rd;
    e.chk_wd = !we; e.wd = cur_wd;
    pend_ack = 1'b0;
    expq.push_back(e);
    tagq.push_back(t);
  endtask

  // expected trace from the timing word in force at accept
  task automatic build(input logic wr, input logic [15:0] addr, wd, input string t);
    int asu  = d2(model_cfg[14:13]);
    int csu  = d2(model_cfg[12:11]);
    int acc  = dacc(model_cfg[10:8]);
    int csh  = d2(model_cfg[7:6]);
    int ah   = d2(model_cfg[5:4]);
    int pacc = dpage(model_cfg[3:2]);
    int nb   = wr ? 1 : dbeats(model_cfg[1:0]);
    logic [15:0] mask = 16'(nb - 1);
    logic [15:0] a = addr;
    cur_wr = wr; cur_wd = wd;
    repeat (asu) add_cyc(1, 1, 1, a, 0, t);
    repeat (csu) add_cyc(0, 1, 1, a, 0, t);
    for (int k = 0; k < nb; k++) begin
      a = (addr & ~mask) | ((addr + 16'(k)) & mask);
      repeat ((k == 0) ? acc : pacc) add_cyc(0, wr, !wr, a, 0, t);
      pend_ack = 1'b1;
      pend_rd  = rdf(a);
    end
    repeat (csh) add_cyc(0, 1, 1, a, 0, t);
    repeat (ah)  add_cyc(1, 1, 1, a, 0, t);
    add_cyc(1, 1, 1, 16'h0000, 1, t);
  endtask

  task automatic do_req(input logic wr, input logic [15:0] addr, wd, input string t);
    logic r;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    forever begin
      r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    build(wr, addr, wd, t);
  endtask

  task automatic drop();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [14:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg = w;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t  e;
    string t;
    logic  ok;
    if (rst_n && !done) begin
      total++;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        t = tagq.pop_front();
        ok = (mem_cs_n === e.cs) && (mem_oe_n === e.oe) && (mem_we_n === e.we) &&
             (mem_addr === e.addr) && (req_ready === e.rdy) && (beat_ack === e.ack) &&
             (!e.chk_rd || rd_data === e.rd) && (!e.chk_wd || mem_wdata === e.wd);
        if (!ok) begin
          bad++;
          $display("FAIL %s: got cs=%b oe=%b we=%b addr=%h rdy=%b ack=%b rd=%h wd=%h exp cs=%b oe=%b we=%b addr=%h rdy=%b ack=%b rd=%h wd=%h",
                   t, mem_cs_n, mem_oe_n, mem_we_n, mem_addr, req_ready, beat_ack, rd_data,
                   mem_wdata, e.cs, e.oe, e.we, e.addr, e.rdy, e.ack, e.rd, e.wd);
        end
      end else begin
        ok = req_ready && mem_cs_n && mem_oe_n && mem_we_n && !beat_ack && (mem_addr == 16'h0);
        if (!ok) begin
          bad++;
          $display("FAIL R9 idle: got rdy=%b cs=%b oe=%b we=%b ack=%b addr=%h exp 1 1 1 1 0 0000",
                   req_ready, mem_cs_n, mem_oe_n, mem_we_n, beat_ack, mem_addr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    pend_ack = 1'b0; pend_rd = '0; cur_wr = 1'b0; cur_wd = '0;
    model_cfg = 15'h0700;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and default 14-clock access
    do_req(0, 16'h1234, 16'h0, "R1 default word"); drop(); drain();

    // R3 R4: mixed delay codes
    wcfg(mk(2'd1, 2'd2, 3'd3, 2'd1, 2'd2, 2'd0, 2'd0));
    do_req(0, 16'h2001, 16'h0, "R3,R4 mixed codes"); drop(); drain();
    wcfg(mk(2'd3, 2'd3, 3'd6, 2'd3, 2'd3, 2'd0, 2'd0));
    do_req(0, 16'h0BEE, 16'h0, "R3,R4 long codes"); drop(); drain();
    wcfg(mk(2'd0, 2'd1, 3'd5, 2'd0, 2'd1, 2'd0, 2'd0));
    do_req(0, 16'h7777, 16'h0, "R2,R4 partial skip"); drop(); drain();

    // R2: all optional phases zero
    wcfg(mk(2'd0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0));
    do_req(0, 16'h00A5, 16'h0, "R2 zero phases"); drop(); drain();
    wcfg(mk(2'd2, 2'd0, 3'd4, 2'd2, 2'd0, 2'd0, 2'd0));
    do_req(0, 16'h5A00, 16'h0, "R2,R4 alt skip"); drop(); drain();

    // R5 R7 R8: page bursts with wrap
    wcfg(mk(2'd1, 2'd0, 3'd2, 2'd1, 2'd0, 2'd0, 2'd1));
    do_req(0, 16'h4ABE, 16'h0, "R5,R7,R8 page4 wrap"); drop(); drain();
    wcfg(mk(2'd0, 2'd0, 3'd1, 2'd0, 2'd0, 2'd3, 2'd2));
    do_req(0, 16'h0013, 16'h0, "R5,R7,R8 page8"); drop(); drain();
    wcfg(mk(2'd2, 2'd1, 3'd0, 2'd0, 2'd2, 2'd1, 2'd3));
    do_req(0, 16'hFFF5, 16'h0, "R5,R7,R8 page16"); drop(); drain();
    wcfg(mk(2'd0, 2'd0, 3'd3, 2'd0, 2'd0, 2'd2, 2'd1));
    do_req(0, 16'h8000, 16'h0, "R5,R7 page4 aligned"); drop(); drain();

    // R6: writes single beat even with page config
    wcfg(mk(2'd1, 2'd1, 3'd1, 2'd1, 2'd1, 2'd1, 2'd3));
    do_req(1, 16'h3456, 16'hBEEF, "R6 write page cfg"); drop(); drain();
    wcfg(mk(2'd1, 2'd1, 3'd4, 2'd2, 2'd1, 2'd0, 2'd0));
    do_req(1, 16'hC0DE, 16'h1357, "R6 write"); drop(); drain();

    // R9: held requests back to back
    wcfg(mk(2'd0, 2'd1, 3'd1, 2'd1, 2'd2, 2'd0, 2'd1));
    do_req(0, 16'h1100, 16'h0, "R9 first");
    do_req(1, 16'h2203, 16'hA5A5, "R9 second");
    do_req(0, 16'h3302, 16'h0, "R9 third");
    drop(); drain();

    // R10: word written during a transaction affects later requests only
    wcfg(mk(2'd1, 2'd1, 3'd2, 2'd1, 2'd1, 2'd0, 2'd0));
    do_req(0, 16'h6060, 16'h0, "R10 old word"); drop();
    repeat (2) @(negedge clk);
    wcfg(mk(2'd0, 2'd0, 3'd7, 2'd0, 2'd0, 2'd0, 2'd1));
    drain();
    do_req(0, 16'h9091, 16'h0, "R10 new word"); drop(); drain();

    // R1: reset returns the default word
    @(negedge clk); rst_n = 1'b0;
    model_cfg = 15'h0700;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_req(0, 16'h0042, 16'h0, "R1 after reset"); drop(); drain();

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule